// File: doc/BRIEF.md
# Window-Compare Response Recorder

This block records the response of one tester pin, one entry per vector step. Two comparator flags arrive from the analog front end without any relation to the local clock. One flag says the pin voltage is at or above the upper threshold. The other says it is at or below the lower threshold. The block passes both flags through a synchronizer and then places the step in one of three classes: high, low, or invalid (the voltage lies between the thresholds). Each recorded step writes a data bit and an invalid bit into a record store at the next free address.

A step is captured when the vector-clock strobe is high and one of two conditions holds. Either the step is marked as an input step, or the step is an output step and the drive/verify monitor option is on. The pin's input is wired to its own driver, so the second condition records the level the pin was driven to. Start and stop inputs control a run. An address counter advances on each write. When the store fills, the block raises an overflow flag and stops writing. When no run is active, a host can read any entry as a {invalid, data} pair. The thresholds can change during a run. The comparator flags are then simply sampled again on each step, and capture continues without a gap.

Top module: `wcr_recorder`

## Requirements
- R1: A captured step with only the upper flag set is stored as rd_data = 2'b01 (bit 1 invalid = 0, bit 0 data = 1).
- R2: A captured step with only the lower flag set is stored as rd_data = 2'b00.
- R3: A captured step with neither flag set is stored as rd_data = 2'b10 (invalid = 1, data forced to 0).
- R4: A captured step with both flags set is treated as invalid and stored as 2'b10.
- R5: During a run, each captured step advances rec_count by exactly one, and entries fill addresses 0, 1, 2 and onward in step order.
- R6: A step is captured only when vec_strobe is 1 and either step_is_input is 1, or step_is_output and monitor_drive are both 1. A step that meets neither condition, or has no strobe, writes nothing.
- R7: A step sampled at a rising edge is written at the third rising edge, counting the sampling edge as the first. rec_count shows the new value after that edge.
- R8: start clears rec_count and overflow, sets running and discards steps still in flight. stop clears running. A step whose write would land while running is 0 is dropped.
- R9: After DEPTH (1024) writes, overflow becomes 1 and running becomes 0. rec_count then holds at DEPTH and later steps are ignored until the next start.
- R10: One cycle after rd_addr is presented while running is 0, rd_data returns the stored {invalid, data} pair. While running is 1, rd_data reads as 0.
- R11: After reset, running, overflow, rec_count and rd_data are all 0.
- R12: Steps on consecutive cycles, with the flags changing every cycle, are all recorded, none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; clears count and overflow |
| stop | input | 1 | End the run |
| vec_strobe | input | 1 | One-cycle vector-clock step strobe |
| step_is_input | input | 1 | Decoded step is an input step |
| step_is_output | input | 1 | Decoded step is an output step |
| monitor_drive | input | 1 | Record driven level on output steps |
| cmp_above_hi | input | 1 | Asynchronous flag: pin at or above upper threshold |
| cmp_below_lo | input | 1 | Asynchronous flag: pin at or below lower threshold |
| rd_addr | input | 10 | Host read address |
| running | output | 1 | Run active |
| overflow | output | 1 | Record store filled during this run |
| rec_count | output | 11 | Entries written this run |
| rd_data | output | 2 | Read result {invalid, data} |

## Verification
The bench aims at the corner cases of this block and at the fault each one would expose:

- **Both flags set.** A design that gave one flag priority would store a valid bit where invalid is required.
- **Band between thresholds.** A design that stored the raw flag would leave the data bit at 1, or would not set the invalid bit.
- **Capture gate.** The bench sends output steps with the monitor option off, and non-strobe cycles. A capture gate that ignored the monitor option or the strobe would advance the count.
- **Write timing.** The count is checked on exact cycles. An enable pipeline whose depth did not match the synchronizer would move the write by a cycle, or pair a step with the wrong flags.
- **Overflow.** After a fill, a counter that kept wrapping would overwrite address 0 and report a count that is not 1024.

// File: rtl/wcr_pkg.sv
package wcr_pkg;

    // One record entry: invalid flag above data bit.
    typedef struct packed {
        logic inv;
        logic data;
    } rec_t;

    typedef enum logic [1:0] {
        CLS_LOW     = 2'd0,
        CLS_HIGH    = 2'd1,
        CLS_INVALID = 2'd2
    } cls_e;

    // One sampled step moving through the synchronizer.
    typedef struct packed {
        logic at_hi;
        logic at_lo;
        logic cap;
    } samp_t;

    function automatic cls_e classify(input logic at_hi, input logic at_lo);
        cls_e c;
        if (at_hi && !at_lo)
            c = CLS_HIGH;
        else if (at_lo && !at_hi)
            c = CLS_LOW;
        else
            c = CLS_INVALID;   // between thresholds, or both flags set
        return c;
    endfunction

    function automatic rec_t encode(input cls_e c);
        rec_t r;
        r.inv  = (c == CLS_INVALID);
        r.data = (c == CLS_HIGH);
        return r;
    endfunction

endpackage

// File: rtl/wcr_sync.sv
module wcr_sync
    import wcr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  samp_t d_in,
    output samp_t d_out
);
    samp_t stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg[s] <= '0;
                end else begin
                    stg[s]     <= d_in;
                    if (flush)
                        stg[s].cap <= 1'b0;
                end
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg[s] <= '0;
                end else begin
                    stg[s]     <= stg[s-1];
                    if (flush)
                        stg[s].cap <= 1'b0;
                end
            end
        end
    end

    assign d_out = stg[STAGES-1];

endmodule

// File: rtl/wcr_classify.sv
module wcr_classify
    import wcr_pkg::*;
(
    input  samp_t smp,
    output logic  req,
    output rec_t  rec
);
    cls_e cls;

    always_comb begin
        cls = classify(smp.at_hi, smp.at_lo);
        rec = encode(cls);
        req = smp.cap;
    end

endmodule

// File: rtl/wcr_ctrl.sv
module wcr_ctrl #(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic              wr_req,
    output logic              running,
    output logic              overflow,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [CNT_W-1:0]  rec_count
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    assign wr_en = wr_req && running;

    always_ff @(posedge clk) begin
        if (rst) begin
            running   <= 1'b0;
            overflow  <= 1'b0;
            wr_addr   <= '0;
            rec_count <= '0;
        end else if (start) begin
            running   <= 1'b1;
            overflow  <= 1'b0;
            wr_addr   <= '0;
            rec_count <= '0;
        end else begin
            if (stop)
                running <= 1'b0;
            if (wr_en) begin
                wr_addr   <= wr_addr + 1'b1;
                rec_count <= rec_count + 1'b1;
                if (wr_addr == LAST_ADDR) begin
                    overflow <= 1'b1;
                    running  <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/wcr_store.sv
module wcr_store
    import wcr_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  rec_t              wr_rec,
    input  logic              rd_block,
    input  logic [ADDR_W-1:0] rd_addr,
    output rec_t              rd_rec
);
    rec_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_rec;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_rec <= '0;
        else if (rd_block)
            rd_rec <= '0;
        else
            rd_rec <= mem[rd_addr];
    end

endmodule

// File: rtl/wcr_recorder.sv
module wcr_recorder
    import wcr_pkg::*;
#(
    parameter int DEPTH       = 1024,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = $clog2(DEPTH),
    parameter int CNT_W       = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic              vec_strobe,
    input  logic              step_is_input,
    input  logic              step_is_output,
    input  logic              monitor_drive,
    input  logic              cmp_above_hi,
    input  logic              cmp_below_lo,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              running,
    output logic              overflow,
    output logic [CNT_W-1:0]  rec_count,
    output logic [1:0]        rd_data
);
    samp_t             smp_in;
    samp_t             smp_sync;
    logic              wr_req;
    logic              wr_en;
    rec_t              wr_rec;
    rec_t              rd_rec;
    logic [ADDR_W-1:0] wr_addr;

    always_comb begin
        smp_in.at_hi = cmp_above_hi;
        smp_in.at_lo = cmp_below_lo;
        smp_in.cap   = vec_strobe &&
                       (step_is_input || (step_is_output && monitor_drive));
    end

    wcr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .flush (start),
        .d_in  (smp_in),
        .d_out (smp_sync)
    );

    wcr_classify u_cls (
        .smp (smp_sync),
        .req (wr_req),
        .rec (wr_rec)
    );

    wcr_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .stop      (stop),
        .wr_req    (wr_req),
        .running   (running),
        .overflow  (overflow),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .rec_count (rec_count)
    );

    wcr_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_rec   (wr_rec),
        .rd_block (running),
        .rd_addr  (rd_addr),
        .rd_rec   (rd_rec)
    );

    assign rd_data = {rd_rec.inv, rd_rec.data};

endmodule

// File: rtl/wcr_recorder_chk.sv
module wcr_recorder_chk #(
    parameter int DEPTH = 1024,
    parameter int CNT_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             running,
    input logic             overflow,
    input logic [CNT_W-1:0] rec_count,
    input logic [1:0]       rd_data
);
    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rec_count <= CNT_W'(DEPTH));

    // R9
    ovf_halts_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |-> !running);

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(start) |-> (rec_count == $past(rec_count) ||
                           rec_count == $past(rec_count) + 1'b1));

    // R8
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (running && !overflow && rec_count == '0));

    // R10
    run_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        running |=> (rd_data == 2'b00));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (overflow && !start) |=> overflow);

endmodule

bind wcr_recorder wcr_recorder_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .running   (running),
    .overflow  (overflow),
    .rec_count (rec_count),
    .rd_data   (rd_data)
);

// File: tb/wcr_recorder_bench.sv
module wcr_recorder_bench;
    localparam int DEPTH = 1024;

    logic        clk = 1'b0;
    logic        rst;
    logic        start, stop, vec_strobe, step_is_input, step_is_output;
    logic        monitor_drive, cmp_above_hi, cmp_below_lo;
    logic [9:0]  rd_addr;
    logic        running, overflow;
    logic [10:0] rec_count;
    logic [1:0]  rd_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    wcr_recorder u_wcr_recorder (
        .clk(clk), .rst(rst), .start(start), .stop(stop),
        .vec_strobe(vec_strobe), .step_is_input(step_is_input),
        .step_is_output(step_is_output), .monitor_drive(monitor_drive),
        .cmp_above_hi(cmp_above_hi), .cmp_below_lo(cmp_below_lo),
        .rd_addr(rd_addr), .running(running), .overflow(overflow),
        .rec_count(rec_count), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    // Drives one strobed step for one cycle.
    task automatic step(input logic hi, input logic lo, input logic si,
                        input logic so, input logic mon);
        @(negedge clk);
        vec_strobe = 1'b1; cmp_above_hi = hi; cmp_below_lo = lo;
        step_is_input = si; step_is_output = so; monitor_drive = mon;
        @(negedge clk);
        vec_strobe = 1'b0; step_is_input = 1'b0; step_is_output = 1'b0;
    endtask

    task automatic read_chk(input string tag, input int addr, input int exp);
        @(negedge clk); rd_addr = 10'(addr);
        @(negedge clk);
        chk(tag, int'(rd_data), exp);
    endtask

    task automatic t_reset();
        chk("R11 running", int'(running), 0);
        chk("R11 overflow", int'(overflow), 0);
        chk("R11 count", int'(rec_count), 0);
        chk("R11 rd_data", int'(rd_data), 0);
    endtask

    task automatic t_classes();
        pulse_start();
        step(1, 0, 1, 0, 0);
        step(0, 1, 1, 0, 0);
        step(0, 0, 1, 0, 0);
        step(1, 1, 1, 0, 0);
        idle(4);
        chk("R5 count after four", int'(rec_count), 4);
        pulse_stop();
        idle(2);
        read_chk("R1 high", 0, 1);
        read_chk("R2 low", 1, 0);
        read_chk("R3 between", 2, 2);
        read_chk("R4 both flags", 3, 2);
    endtask

    task automatic t_gate();
        pulse_start();
        step(1, 0, 0, 1, 0);           // output step, monitor off
        idle(4);
        chk("R6 output w/o monitor", int'(rec_count), 0);
        step(1, 0, 0, 1, 1);           // output step, monitor on
        step(1, 0, 0, 0, 1);           // neither input nor output
        @(negedge clk); step_is_input = 1'b1; vec_strobe = 1'b0;
        @(negedge clk); step_is_input = 1'b0;
        idle(4);
        chk("R6 gate count", int'(rec_count), 1);
        pulse_stop();
        idle(2);
        read_chk("R6 monitored drive", 0, 1);
    endtask

    task automatic t_latency();
        pulse_start();
        @(negedge clk);
        vec_strobe = 1'b1; step_is_input = 1'b1;
        cmp_above_hi = 1'b0; cmp_below_lo = 1'b1;
        @(negedge clk);                // sampling edge passed
        vec_strobe = 1'b0; step_is_input = 1'b0;
        @(negedge clk);                // second edge passed
        chk("R7 not yet written", int'(rec_count), 0);
        @(negedge clk);                // third edge passed
        chk("R7 written third edge", int'(rec_count), 1);
        pulse_stop();
    endtask

    task automatic t_back_to_back();
        logic [1:0] pat [6];
        pat[0] = 2'b10; pat[1] = 2'b01; pat[2] = 2'b00;
        pat[3] = 2'b11; pat[4] = 2'b10; pat[5] = 2'b01;
        pulse_start();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            vec_strobe = 1'b1; step_is_input = 1'b1;
            cmp_above_hi = pat[i][1]; cmp_below_lo = pat[i][0];
        end
        @(negedge clk); vec_strobe = 1'b0; step_is_input = 1'b0;
        idle(4);
        chk("R12 count", int'(rec_count), 6);
        @(negedge clk); rd_addr = 10'd0;
        @(negedge clk);
        chk("R10 read while running", int'(rd_data), 0);
        pulse_stop();
        idle(2);
        for (int i = 0; i < 6; i++) begin
            int e;
            e = (pat[i] == 2'b10) ? 1 : (pat[i] == 2'b01) ? 0 : 2;
            read_chk("R12 entry", i, e);
        end
    endtask

    task automatic t_stop();
        pulse_start();
        chk("R8 start clears count", int'(rec_count), 0);
        chk("R8 running", int'(running), 1);
        pulse_stop();
        chk("R8 stopped", int'(running), 0);
        step(1, 0, 1, 0, 0);
        idle(4);
        chk("R8 no write when stopped", int'(rec_count), 0);
    endtask

    task automatic t_overflow();
        pulse_start();
        @(negedge clk);
        vec_strobe = 1'b1; step_is_input = 1'b1;
        cmp_above_hi = 1'b1; cmp_below_lo = 1'b0;
        idle(DEPTH + 20);
        vec_strobe = 1'b0; step_is_input = 1'b0;
        idle(4);
        chk("R9 overflow", int'(overflow), 1);
        chk("R9 running cleared", int'(running), 0);
        chk("R9 count held", int'(rec_count), DEPTH);
        read_chk("R9 last entry", DEPTH - 1, 1);
        pulse_start();
        chk("R8 start clears overflow", int'(overflow), 0);
        pulse_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; stop = 1'b0; vec_strobe = 1'b0;
        step_is_input = 1'b0; step_is_output = 1'b0; monitor_drive = 1'b0;
        cmp_above_hi = 1'b0; cmp_below_lo = 1'b0; rd_addr = '0;
        idle(4);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_classes();
        t_gate();
        t_latency();
        t_back_to_back();
        t_stop();
        t_overflow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule